// File: doc/BRIEF.md
# Windowed PLL Lock Detector

This block decides whether a phase-locked loop is in lock by watching the two inputs of its phase detector: the reference and the divided oscillator signal. A fast timing clock samples both signals. Each rising edge of the reference opens a window that reaches a set number of timing-clock cycles before and after it. A divided edge that falls inside that window counts as a hit. A divided edge that falls outside every window counts as a miss, and so does a reference edge that sees no divided edge near it.

The lock flag is raised only after a programmed run of consecutive hits. One miss drops the flag at once and starts the run over from zero. The window is either a fixed default width, which is set at build time from the timing-clock period and a nominal window in picoseconds, or a programmable width chosen by a 2-bit code. A test input sends a toggling copy of the timing clock out on a general-purpose pin. While that test input is set, lock detection is held off.

Top module: `pll_lock_window_det`

## Requirements
- R1: After reset, `lock_flag` and `gpo_out` are both 0.
- R2: While `lkd_en` is 0, `lock_flag` is 0 and the hit run is held at zero, so after `lkd_en` returns to 1 a full new run of `hit_thresh` hits is needed before lock.
- R3: When `win_mode` is 0, the window reaches FIXED_HALF timing-clock cycles on each side of a reference edge. With the default parameters this is 1 cycle, so an offset of 1 cycle is a hit and an offset of 2 cycles is a miss.
- R4: When `win_mode` is 1, the window reaches 4 << `dur_code` cycles on each side: 4, 8, 16 or 32 cycles for codes 0 to 3. An offset equal to the half-width is a hit, and one cycle more is a miss. This holds whether the divided edge leads or trails the reference edge.
- R5: `lock_flag` rises only after exactly `hit_thresh` consecutive hits. After one hit fewer, it is still 0.
- R6: A divided edge outside every window clears `lock_flag` on the next cycle and restarts the run from zero.
- R7: A reference edge with no divided edge within its window counts as a miss and clears `lock_flag`.
- R8: Once the run reaches `hit_thresh`, the count saturates and `lock_flag` stays 1 through any number of further hits.
- R9: A `hit_thresh` of 0 behaves as 1.
- R10: While `osc_test` is 1, `gpo_out` toggles on every timing-clock cycle and `lock_flag` is 0. While `osc_test` is 0, `gpo_out` is 0.
- R11: A divided edge that arrives in the same sampled cycle as a reference edge is a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock that samples both edges and times the window |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference signal, asynchronous to clk |
| div_in | input | 1 | Divided oscillator signal, asynchronous to clk |
| lkd_en | input | 1 | Enables lock detection |
| win_mode | input | 1 | 0 selects the fixed window, 1 selects the programmable window |
| dur_code | input | 2 | Half-width code for the programmable window: 4 << code cycles |
| hit_thresh | input | 10 | Number of consecutive hits needed for lock (0 behaves as 1) |
| osc_test | input | 1 | Sends the timing clock to gpo_out and holds off detection |
| lock_flag | output | 1 | Lock indication |
| gpo_out | output | 1 | Toggling copy of the timing clock while osc_test is 1, otherwise 0 |

## Verification
The checks assume that each input pulse stays high or low for at least two timing-clock cycles, so that both synchronizers see every edge. They also assume that the reference period is longer than twice the window plus the synchronizer delay, so windows never overlap, and that the threshold and window settings change only while detection is off. The stimulus keeps to these limits. Every case uses a 120-cycle reference period with 60-cycle high pulses and divided-edge offsets of at most 33 cycles. Settings are changed only while `lkd_en` is held low, which also clears any pending window.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

    // Largest programmable half-window, in timing-clock cycles
    localparam int MAX_HALF = 32;
    // Age counters must be able to show "one past the widest window"
    localparam int AGE_W    = $clog2(MAX_HALF + 2);
    localparam int THR_W    = 10;

    typedef enum logic {
        WIN_FIXED = 1'b0,
        WIN_PROG  = 1'b1
    } win_mode_e;

    // One judgement per timing-clock cycle
    typedef struct packed {
        logic hit;
        logic miss;
    } judge_evt_t;

    // Programmable half-width: 4, 8, 16 or 32 cycles
    function automatic logic [AGE_W-1:0] prog_half(input logic [1:0] code);
        return AGE_W'(4) << code;
    endfunction

    // Fixed half-width: nominal window rounded up to whole clock cycles
    function automatic int fixed_half(input int tclk_ps, input int win_ps);
        return (win_ps + tclk_ps - 1) / tclk_ps;
    endfunction

endpackage

// File: rtl/lkd_edge_sync.sv
module lkd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/lkd_window_judge.sv
module lkd_window_judge
    import lkd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ref_rise,
    input  logic             div_rise,
    input  logic [AGE_W-1:0] half,
    output judge_evt_t       evt
);
    // An edge waits here for its partner; age counts cycles since it arrived
    logic             ref_pend_q, div_pend_q;
    logic [AGE_W-1:0] ref_age_q,  div_age_q;
    logic             ref_pend_d, div_pend_d;
    logic [AGE_W-1:0] ref_age_d,  div_age_d;
    logic             ref_late, div_late;

    always_comb begin
        ref_late = ref_pend_q && (ref_age_q > half);
        div_late = div_pend_q && (div_age_q > half);

        evt.hit  = 1'b0;
        evt.miss = ref_late | div_late;

        ref_pend_d = ref_pend_q & ~ref_late;
        div_pend_d = div_pend_q & ~div_late;
        ref_age_d  = (ref_age_q != '1) ? ref_age_q + AGE_W'(1) : ref_age_q;
        div_age_d  = (div_age_q != '1) ? div_age_q + AGE_W'(1) : div_age_q;

        if (ref_rise && div_rise) begin
            evt.hit = 1'b1;
        end else if (ref_rise) begin
            if (div_pend_q && !div_late) begin
                evt.hit    = 1'b1;
                div_pend_d = 1'b0;
            end else begin
                if (ref_pend_q && !ref_late) evt.miss = 1'b1;
                ref_pend_d = 1'b1;
                ref_age_d  = AGE_W'(1);
            end
        end else if (div_rise) begin
            if (ref_pend_q && !ref_late) begin
                evt.hit    = 1'b1;
                ref_pend_d = 1'b0;
            end else begin
                if (div_pend_q && !div_late) evt.miss = 1'b1;
                div_pend_d = 1'b1;
                div_age_d  = AGE_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ref_pend_q <= 1'b0;
            div_pend_q <= 1'b0;
            ref_age_q  <= '0;
            div_age_q  <= '0;
        end else begin
            ref_pend_q <= ref_pend_d;
            div_pend_q <= div_pend_d;
            ref_age_q  <= ref_age_d;
            div_age_q  <= div_age_d;
        end
    end
endmodule

// File: rtl/lkd_run_counter.sv
module lkd_run_counter
    import lkd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  judge_evt_t       evt,
    input  logic [THR_W-1:0] thr,
    output logic             locked
);
    logic [THR_W-1:0] run_q;
    logic [THR_W-1:0] run_d;
    logic [THR_W-1:0] thr_eff;

    assign thr_eff = (thr == '0) ? THR_W'(1) : thr;

    always_comb begin
        run_d = run_q;
        if (run_q < thr_eff) run_d = run_q + THR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q  <= '0;
            locked <= 1'b0;
        end else if (evt.miss) begin
            run_q  <= '0;
            locked <= 1'b0;
        end else if (evt.hit) begin
            run_q  <= run_d;
            locked <= (run_d >= thr_eff);
        end
    end
endmodule

// File: rtl/pll_lock_window_det.sv
module pll_lock_window_det
    import lkd_pkg::*;
#(
    parameter int TCLK_PS      = 10000,
    parameter int FIXED_WIN_PS = 10000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             div_in,
    input  logic             lkd_en,
    input  logic             win_mode,
    input  logic [1:0]       dur_code,
    input  logic [THR_W-1:0] hit_thresh,
    input  logic             osc_test,
    output logic             lock_flag,
    output logic             gpo_out
);
    localparam int FIXED_HALF = fixed_half(TCLK_PS, FIXED_WIN_PS);

    logic [1:0]       raw_edges;
    logic [1:0]       rise_edges;
    logic [AGE_W-1:0] half;
    logic             hold_off;
    judge_evt_t       evt;

    assign raw_edges = {div_in, ref_in};
    assign hold_off  = !lkd_en || osc_test;
    assign half      = (win_mode_e'(win_mode) == WIN_PROG) ? prog_half(dur_code)
                                                           : AGE_W'(FIXED_HALF);

    for (genvar gi = 0; gi < 2; gi++) begin : g_sync
        lkd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_edges[gi]),
            .rise (rise_edges[gi])
        );
    end

    lkd_window_judge u_judge (
        .clk      (clk),
        .rst      (rst),
        .clr      (hold_off),
        .ref_rise (rise_edges[0]),
        .div_rise (rise_edges[1]),
        .half     (half),
        .evt      (evt)
    );

    lkd_run_counter u_run (
        .clk    (clk),
        .rst    (rst),
        .clr    (hold_off),
        .evt    (evt),
        .thr    (hit_thresh),
        .locked (lock_flag)
    );

    always_ff @(posedge clk) begin
        if (rst)           gpo_out <= 1'b0;
        else if (osc_test) gpo_out <= ~gpo_out;
        else               gpo_out <= 1'b0;
    end
endmodule

// File: rtl/lkd_chk.sv
module lkd_chk (
    input logic clk,
    input logic rst,
    input logic lkd_en,
    input logic osc_test,
    input logic lock_flag,
    input logic gpo_out,
    input logic miss
);
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        // R1
        if (rst_q) begin
            reset_state_chk: assert (!lock_flag && !gpo_out);
        end
    end

    // R2
    en_off_chk: assert property (@(posedge clk) disable iff (rst)
        !lkd_en |=> !lock_flag);

    // R10
    test_lock_chk: assert property (@(posedge clk) disable iff (rst)
        osc_test |=> !lock_flag);

    // R10
    gpo_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        osc_test |=> gpo_out != $past(gpo_out));

    // R10
    gpo_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_test |=> !gpo_out);

    // R6
    miss_clear_chk: assert property (@(posedge clk) disable iff (rst)
        miss |=> !lock_flag);
endmodule

bind pll_lock_window_det lkd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lkd_en    (lkd_en),
    .osc_test  (osc_test),
    .lock_flag (lock_flag),
    .gpo_out   (gpo_out),
    .miss      (evt.miss)
);

// File: tb/pll_lock_window_det_bench.sv
module pll_lock_window_det_bench;
    localparam int P = 120;

    typedef struct packed {
        logic              prog;
        logic [1:0]        code;
        logic signed [7:0] off;
        logic              exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0,  8'sd0,   1'b1},
        '{1'b0, 2'd0,  8'sd1,   1'b1},
        '{1'b0, 2'd0,  8'sd2,   1'b0},
        '{1'b0, 2'd0, -8'sd1,   1'b1},
        '{1'b0, 2'd0, -8'sd2,   1'b0},
        '{1'b1, 2'd0,  8'sd4,   1'b1},
        '{1'b1, 2'd0,  8'sd5,   1'b0},
        '{1'b1, 2'd0, -8'sd4,   1'b1},
        '{1'b1, 2'd0, -8'sd5,   1'b0},
        '{1'b1, 2'd1,  8'sd8,   1'b1},
        '{1'b1, 2'd1,  8'sd9,   1'b0},
        '{1'b1, 2'd2, -8'sd16,  1'b1},
        '{1'b1, 2'd2,  8'sd17,  1'b0},
        '{1'b1, 2'd3,  8'sd32,  1'b1},
        '{1'b1, 2'd3, -8'sd33,  1'b0},
        '{1'b1, 2'd3, -8'sd32,  1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_in = 1'b0, div_in = 1'b0;
    logic       lkd_en = 1'b0, win_mode = 1'b0, osc_test = 1'b0;
    logic [1:0] dur_code = 2'd0;
    logic [9:0] hit_thresh = 10'd4;
    logic       lock_flag, gpo_out;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    pll_lock_window_det u_pll_lock_window_det (
        .clk(clk), .rst(rst), .ref_in(ref_in), .div_in(div_in),
        .lkd_en(lkd_en), .win_mode(win_mode), .dur_code(dur_code),
        .hit_thresh(hit_thresh), .osc_test(osc_test),
        .lock_flag(lock_flag), .gpo_out(gpo_out)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // n reference periods; divided edge offset by off cycles (negative leads)
    task automatic run_periods(input int n, input int off, input bit has_div);
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < P; c++) begin
                int  ph;
                logic dv;
                @(negedge clk);
                ref_in = (c < P / 2);
                ph = ((c - off) % P + P) % P;
                dv = has_div && (ph < P / 2);
                if (off < 0 && k == n - 1 && c >= P + off) dv = 1'b0;
                div_in = dv;
            end
        end
        @(negedge clk);
        ref_in = 1'b0;
        div_in = 1'b0;
        idle(6);
    endtask

    task automatic restart(input logic prog, input logic [1:0] code, input logic [9:0] thr);
        lkd_en = 1'b0;
        idle(4);
        win_mode   = prog;
        dur_code   = code;
        hit_thresh = thr;
        lkd_en     = 1'b1;
        idle(2);
    endtask

    initial begin
        idle(3);
        chk("R1 lock after reset", lock_flag, 1'b0);
        chk("R1 gpo after reset", gpo_out, 1'b0);
        rst = 1'b0;
        idle(2);

        // R3 R4 R11: window edges, fixed and programmable, leading and trailing
        for (int v = 0; v < NV; v++) begin
            restart(VECS[v].prog, VECS[v].code, 10'd4);
            run_periods(6, int'(VECS[v].off), 1'b1);
            chk(VECS[v].prog ? "R4 window vector" : "R3 R11 window vector",
                lock_flag, VECS[v].exp);
        end

        // R5 exact threshold
        restart(1'b0, 2'd0, 10'd5);
        run_periods(4, 0, 1'b1);
        chk("R5 one hit short", lock_flag, 1'b0);
        run_periods(1, 0, 1'b1);
        chk("R5 threshold reached", lock_flag, 1'b1);

        // R8 saturation
        run_periods(20, 0, 1'b1);
        chk("R8 held after extra hits", lock_flag, 1'b1);

        // R6 one outside edge clears and restarts
        run_periods(1, 3, 1'b1);
        chk("R6 cleared by miss", lock_flag, 1'b0);
        run_periods(4, 0, 1'b1);
        chk("R6 run restarted", lock_flag, 1'b0);
        run_periods(1, 0, 1'b1);
        chk("R6 relock", lock_flag, 1'b1);

        // R7 reference with no divided edge
        run_periods(1, 0, 1'b0);
        chk("R7 missing divided edge", lock_flag, 1'b0);

        // R9 threshold zero
        restart(1'b0, 2'd0, 10'd0);
        run_periods(1, 0, 1'b1);
        chk("R9 zero threshold", lock_flag, 1'b1);

        // R2 enable gating
        restart(1'b0, 2'd0, 10'd3);
        run_periods(3, 0, 1'b1);
        chk("R2 locked before disable", lock_flag, 1'b1);
        lkd_en = 1'b0;
        idle(2);
        chk("R2 cleared by disable", lock_flag, 1'b0);
        run_periods(5, 0, 1'b1);
        chk("R2 no lock while disabled", lock_flag, 1'b0);
        lkd_en = 1'b1;
        run_periods(2, 0, 1'b1);
        chk("R2 run restarted", lock_flag, 1'b0);
        run_periods(1, 0, 1'b1);
        chk("R2 relock", lock_flag, 1'b1);

        // R10 test output
        osc_test = 1'b1;
        idle(3);
        begin
            logic g1;
            g1 = gpo_out;
            idle(1);
            chk("R10 gpo toggles", gpo_out, ~g1);
        end
        chk("R10 lock off in test", lock_flag, 1'b0);
        run_periods(3, 0, 1'b1);
        chk("R10 no lock in test", lock_flag, 1'b0);
        osc_test = 1'b0;
        idle(3);
        chk("R10 gpo idle", gpo_out, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule